// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is a serial peripheral master that runs a list of up to sixteen transfers from an internal queue, so the host does not have to attend to every word. Each queue slot holds three things: an outgoing word, an incoming word and a command byte whose options include the transfer length. The host fills the queue through two registers: an address register that selects a slot and a data register that reads or writes it. The address steps forward after every data access, so a segment can be filled in one burst.

The host then sets a start pointer and an end pointer and enables the engine. The engine works through the slots in order. It shifts each word out most significant bit first, in any of the four clock polarity and phase modes, and stores what it receives in the matching receive slot. When the slot just finished equals the end pointer, it raises a finished flag. It then stops, or it carries on around the queue if wraparound is enabled. The host can move the start pointer while the queue is running. The transfer in flight always completes first.

Top module: `qspi_queue_master`

## Requirements
- R1: After a synchronous reset the chip select (`spi_cs_n`) is high, the serial clock is low, the finished flag is 0, and the mode, pointer and address registers read 0.
- R2: Host register select codes: 0 baud, 1 mode, 2 pointers, 3 status, 4 queue address, 5 queue data. Queue addresses are 6 bits: 0x00-0x0F transmit, 0x10-0x1F receive, 0x20-0x2F command, 0x30-0x3F unmapped. Every read or write of the data register adds 1 to the queue address, and the address can be read back.
- R3: Host writes to the receive segment or to unmapped addresses change nothing. Host reads of the transmit segment, the command segment or unmapped addresses return 0.
- R4: Mode register bits: bit 0 enable, bit 1 clock phase, bit 2 clock polarity. Pointer register bits: [3:0] start pointer, [7:4] end pointer, bit 8 wraparound, [15:12] completed pointer (read only). Setting the enable bit from 0 to 1 starts execution at the start pointer. After each slot the engine records that slot as the completed pointer and moves to the next slot.
- R5: When a slot equal to the end pointer completes and wraparound is off, the finished flag (status bit 0, also the `q_finished` pin) is set, the enable bit clears and no further transfer starts.
- R6: With wraparound on, the engine continues past the end pointer: slot 15 is followed by slot 0. The finished flag is set every time the end slot completes. Clearing the enable bit lets the current transfer finish and then stops the engine.
- R7: With both pointers at 0, enabling the engine performs exactly one transfer, of slot 0.
- R8: A start pointer written during a transfer does not cut that transfer short. The next slot executed is the newly written pointer.
- R9: Data is shifted most significant bit first. With clock phase 0, data is sampled on the leading clock edge; with phase 1, on the trailing edge. The idle clock level equals the polarity bit.
- R10: Transfer length comes from command bit 7 and bits [3:0]. If bit 7 is 0 the length is 8 bits. If bit 7 is 1, a value of 8-15 in [3:0] gives that many bits, 0 gives 16 bits, and 1-7 give 8 bits.
- R11: Each half period of the serial clock lasts baud+1 clock cycles, so chip select stays low for exactly 2 × length × (baud+1) cycles per transfer.
- R12: Writing 1 to status bit 0 clears the finished flag. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_sel | input | 3 | Host register select |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe (advances the address on data reads) |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, combinational on `hst_sel` |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, low while a word is shifting |
| q_finished | output | 1 | Finished flag |

## Verification
A register write takes effect at the clock edge that samples the strobe. Chip select falls two edges after the enabling write, stays low for exactly 2 × length × (baud+1) cycles, and the finished flag rises one edge after chip select returns high. The next slot's chip select falls two edges after the previous one rises. The bench samples every output on the falling clock edge, counts the low time of chip select and the sampling edges of the serial clock cycle by cycle, and waits on the finished flag with a bounded poll before it reads any register. Checks that depend on timing, such as the pointer update during a transfer and disabling while in wraparound, rely only on margins the transfer length guarantees.

// File: rtl/qspiq_pkg.sv
package qspiq_pkg;

    localparam int Q_PW = 4;                  // queue pointer width
    localparam int Q_AW = Q_PW + 2;           // host queue address width
    localparam int Q_WW = 16;                 // data word width
    localparam int Q_CW = 8;                  // command byte width
    localparam int Q_BW = 8;                  // baud divider width
    localparam int Q_NW = $clog2(Q_WW + 1);   // bit-count width

    localparam logic [2:0] SEL_BAUD = 3'd0;
    localparam logic [2:0] SEL_MODE = 3'd1;
    localparam logic [2:0] SEL_QPTR = 3'd2;
    localparam logic [2:0] SEL_STAT = 3'd3;
    localparam logic [2:0] SEL_ADDR = 3'd4;
    localparam logic [2:0] SEL_DATA = 3'd5;

    typedef enum logic [1:0] {SEG_TX, SEG_RX, SEG_CMD, SEG_NONE} seg_e;
    typedef enum logic [1:0] {Q_IDLE, Q_LAUNCH, Q_XFER} qstate_e;

    typedef struct packed {
        logic            cpol;
        logic            cpha;
        logic [Q_BW-1:0] baud;
    } spi_cfg_t;

    function automatic seg_e seg_of(input logic [Q_AW-1:0] a);
        case (a[Q_AW-1:Q_AW-2])
            2'b00:   return SEG_TX;
            2'b01:   return SEG_RX;
            2'b10:   return SEG_CMD;
            default: return SEG_NONE;
        endcase
    endfunction

    // transfer length from a command byte
    function automatic logic [Q_NW-1:0] cmd_len(input logic [Q_CW-1:0] c);
        if (!c[7])                return Q_NW'(8);
        else if (c[3:0] == 4'd0)  return Q_NW'(16);
        else if (c[3:0] < 4'd8)   return Q_NW'(8);
        else                      return Q_NW'(c[3:0]);
    endfunction

endpackage

// File: rtl/qspiq_store.sv
module qspiq_store
    import qspiq_pkg::*;
#(
    parameter int PW = Q_PW,
    parameter int WW = Q_WW,
    parameter int CW = Q_CW
) (
    input  logic          clk,
    input  logic          host_we,
    input  logic [PW+1:0] host_addr,
    input  logic [WW-1:0] host_wdata,
    output logic [WW-1:0] host_rdata,
    input  logic [PW-1:0] eng_idx,
    output logic [WW-1:0] eng_tx,
    output logic [CW-1:0] eng_cmd,
    input  logic          eng_rx_we,
    input  logic [WW-1:0] eng_rx_data
);
    localparam int DEPTH = 1 << PW;

    logic [WW-1:0] tx_mem  [DEPTH];
    logic [WW-1:0] rx_mem  [DEPTH];
    logic [CW-1:0] cmd_mem [DEPTH];

    seg_e          hseg;
    logic [PW-1:0] hidx;

    assign hseg = seg_of(host_addr);
    assign hidx = host_addr[PW-1:0];

    always_ff @(posedge clk) begin
        if (host_we && hseg == SEG_TX)  tx_mem[hidx]  <= host_wdata;
        if (host_we && hseg == SEG_CMD) cmd_mem[hidx] <= host_wdata[CW-1:0];
        if (eng_rx_we)                  rx_mem[eng_idx] <= eng_rx_data;
    end

    // only the receive segment is visible to host reads
    assign host_rdata = (hseg == SEG_RX) ? rx_mem[hidx] : '0;
    assign eng_tx     = tx_mem[eng_idx];
    assign eng_cmd    = cmd_mem[eng_idx];

endmodule

// File: rtl/qspiq_shifter.sv
module qspiq_shifter
    import qspiq_pkg::*;
#(
    parameter int WW = Q_WW,
    parameter int BW = Q_BW,
    parameter int NW = Q_NW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [WW-1:0] tx,
    input  logic [NW-1:0] nbits,
    input  spi_cfg_t      cfg,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          busy,
    output logic          done,
    output logic [WW-1:0] rx
);
    logic [BW-1:0] cnt;
    logic [NW:0]   eidx;
    logic [NW:0]   last_e;
    logic [NW-1:0] nb_q;
    logic [WW-1:0] sreg;
    logic          tog;
    logic          cph_q;
    logic          samp;

    assign last_e = {nb_q, 1'b0} - 1'b1;
    assign samp   = (~eidx[0]) ^ cph_q;   // leading edge when eidx even
    assign sclk   = cfg.cpol ^ tog;
    assign mosi   = sreg[WW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            tog   <= 1'b0;
            cnt   <= '0;
            eidx  <= '0;
            nb_q  <= '0;
            sreg  <= '0;
            rx    <= '0;
            cph_q <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    tog   <= 1'b0;
                    cnt   <= cfg.baud;
                    eidx  <= '0;
                    nb_q  <= nbits;
                    sreg  <= tx << (WW - int'(nbits));
                    rx    <= '0;
                    cph_q <= cfg.cpha;
                end
            end else if (cnt == '0) begin
                cnt  <= cfg.baud;
                tog  <= ~tog;
                eidx <= eidx + 1'b1;
                if (samp)
                    rx <= {rx[WW-2:0], miso};
                else if (eidx != '0)
                    sreg <= sreg << 1;
                if (eidx == last_e) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R9: clock is back at its idle level when a word ends
    p_idle_level_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (sclk == cfg.cpol));

endmodule

// File: rtl/qspiq_sequencer.sv
module qspiq_sequencer
    import qspiq_pkg::*;
#(
    parameter int PW = Q_PW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          en_load,
    input  logic [PW-1:0] newqp,
    input  logic          newqp_wr,
    input  logic [PW-1:0] endqp,
    input  logic          wrap,
    input  logic          shf_busy,
    input  logic          shf_done,
    output logic [PW-1:0] ptr,
    output logic [PW-1:0] cpt,
    output logic          start,
    output logic          rx_we,
    output logic          fin_set,
    output logic          stop
);
    qstate_e st;
    logic    pend;

    assign start   = (st == Q_LAUNCH);
    assign rx_we   = (st == Q_XFER) && shf_done;
    assign fin_set = rx_we && (ptr == endqp);
    assign stop    = fin_set && !wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= Q_IDLE;
            ptr  <= '0;
            cpt  <= '0;
            pend <= 1'b0;
        end else begin
            unique case (st)
                Q_IDLE: begin
                    if (en_load) begin
                        ptr  <= newqp;
                        pend <= 1'b0;
                        st   <= Q_LAUNCH;
                    end else if (newqp_wr) begin
                        ptr <= newqp;
                    end
                end
                Q_LAUNCH: begin
                    if (newqp_wr) pend <= 1'b1;
                    st <= Q_XFER;
                end
                Q_XFER: begin
                    if (shf_done) begin
                        cpt  <= ptr;
                        ptr  <= (pend || newqp_wr) ? newqp : ptr + 1'b1;
                        pend <= 1'b0;
                        st   <= (stop || !en) ? Q_IDLE : Q_LAUNCH;
                    end else if (newqp_wr) begin
                        pend <= 1'b1;
                    end
                end
                default: st <= Q_IDLE;
            endcase
        end
    end

    // R4: a word is only launched into an idle shifter
    p_launch_idle_r4: assert property (@(posedge clk) disable iff (rst)
        start |-> !shf_busy);

    // R5: finishing reports the end pointer as completed
    p_fin_at_end_r5: assert property (@(posedge clk) disable iff (rst)
        fin_set |=> (cpt == $past(endqp)));

    // R8: a pointer write mid-transfer leaves the live pointer alone
    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (st == Q_XFER && !shf_done && newqp_wr) |=> (ptr == $past(ptr)));

endmodule

// File: rtl/qspi_queue_master.sv
module qspi_queue_master
    import qspiq_pkg::*;
#(
    parameter int PW = Q_PW,
    parameter int WW = Q_WW,
    parameter int CW = Q_CW,
    parameter int BW = Q_BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    hst_sel,
    input  logic          hst_wr,
    input  logic          hst_rd,
    input  logic [15:0]   hst_wdata,
    output logic [15:0]   hst_rdata,
    output logic          spi_sclk,
    output logic          spi_mosi,
    input  logic          spi_miso,
    output logic          spi_cs_n,
    output logic          q_finished
);
    localparam int AW = PW + 2;
    localparam int NW = $clog2(WW + 1);

    logic [BW-1:0] baud_q;
    logic          en_q, cpha_q, cpol_q, wrap_q, fin_q;
    logic [PW-1:0] newqp_q, endqp_q;
    logic [AW-1:0] addr_q;

    logic          wr_mode, wr_qptr, wr_stat, wr_addr, data_acc, en_load;
    logic [PW-1:0] newqp_eff, ptr, cpt;
    logic          start, rx_we, fin_set, stop, busy, done;
    logic [WW-1:0] eng_tx, rx_word, store_rdata;
    logic [CW-1:0] eng_cmd;
    spi_cfg_t      cfg;

    assign wr_mode   = hst_wr && hst_sel == SEL_MODE;
    assign wr_qptr   = hst_wr && hst_sel == SEL_QPTR;
    assign wr_stat   = hst_wr && hst_sel == SEL_STAT;
    assign wr_addr   = hst_wr && hst_sel == SEL_ADDR;
    assign data_acc  = (hst_wr || hst_rd) && hst_sel == SEL_DATA;
    assign en_load   = wr_mode && hst_wdata[0] && !en_q;
    assign newqp_eff = wr_qptr ? hst_wdata[PW-1:0] : newqp_q;
    assign cfg       = '{cpol: cpol_q, cpha: cpha_q, baud: baud_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            baud_q  <= '0;
            en_q    <= 1'b0;
            cpha_q  <= 1'b0;
            cpol_q  <= 1'b0;
            wrap_q  <= 1'b0;
            fin_q   <= 1'b0;
            newqp_q <= '0;
            endqp_q <= '0;
            addr_q  <= '0;
        end else begin
            if (hst_wr && hst_sel == SEL_BAUD) baud_q <= hst_wdata[BW-1:0];
            if (stop)
                en_q <= 1'b0;
            else if (wr_mode)
                en_q <= hst_wdata[0];
            if (wr_mode) begin
                cpha_q <= hst_wdata[1];
                cpol_q <= hst_wdata[2];
            end
            if (wr_qptr) begin
                newqp_q <= hst_wdata[PW-1:0];
                endqp_q <= hst_wdata[PW+3:4];
                wrap_q  <= hst_wdata[8];
            end
            if (fin_set)
                fin_q <= 1'b1;
            else if (wr_stat && hst_wdata[0])
                fin_q <= 1'b0;
            if (wr_addr)
                addr_q <= hst_wdata[AW-1:0];
            else if (data_acc)
                addr_q <= addr_q + 1'b1;
        end
    end

    always_comb begin
        hst_rdata = '0;
        case (hst_sel)
            SEL_BAUD: hst_rdata[BW-1:0] = baud_q;
            SEL_MODE: hst_rdata[2:0]    = {cpol_q, cpha_q, en_q};
            SEL_QPTR: hst_rdata         = {cpt, 3'b000, wrap_q, endqp_q, newqp_q};
            SEL_STAT: hst_rdata[0]      = fin_q;
            SEL_ADDR: hst_rdata[AW-1:0] = addr_q;
            SEL_DATA: hst_rdata         = store_rdata;
            default:  hst_rdata         = '0;
        endcase
    end

    qspiq_store #(.PW(PW), .WW(WW), .CW(CW)) u_store (
        .clk         (clk),
        .host_we     (hst_wr && hst_sel == SEL_DATA),
        .host_addr   (addr_q),
        .host_wdata  (hst_wdata),
        .host_rdata  (store_rdata),
        .eng_idx     (ptr),
        .eng_tx      (eng_tx),
        .eng_cmd     (eng_cmd),
        .eng_rx_we   (rx_we),
        .eng_rx_data (rx_word)
    );

    qspiq_sequencer #(.PW(PW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (en_q),
        .en_load  (en_load),
        .newqp    (newqp_eff),
        .newqp_wr (wr_qptr),
        .endqp    (endqp_q),
        .wrap     (wrap_q),
        .shf_busy (busy),
        .shf_done (done),
        .ptr      (ptr),
        .cpt      (cpt),
        .start    (start),
        .rx_we    (rx_we),
        .fin_set  (fin_set),
        .stop     (stop)
    );

    qspiq_shifter #(.WW(WW), .BW(BW), .NW(NW)) u_shf (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .tx    (eng_tx),
        .nbits (cmd_len(eng_cmd)),
        .cfg   (cfg),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .busy  (busy),
        .done  (done),
        .rx    (rx_word)
    );

    assign spi_cs_n   = ~busy;
    assign q_finished = fin_q;

    // R5: reaching the end without wraparound drops the enable bit
    p_stop_clears_en_r5: assert property (@(posedge clk) disable iff (rst)
        (fin_set && !wrap_q) |=> !en_q);

    // R2: every data-register access steps the queue address
    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        data_acc |=> (addr_q == $past(addr_q) + 1'b1));

endmodule

// File: tb/qspi_queue_master_tb.sv
module qspi_queue_master_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  hst_sel = '0;
    logic        hst_wr = 1'b0;
    logic        hst_rd = 1'b0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n, q_finished;

    int n_chk = 0;
    int n_fail = 0;
    bit all_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign spi_miso = ~spi_mosi;   // slave answers with the inverted bit

    qspi_queue_master u_dut (
        .clk(clk), .rst(rst), .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
        .q_finished(q_finished)
    );

    // {cpol, cpha, cmd[7:0], tx[15:0], baud[7:0]}
    localparam logic [33:0] VEC [8] = '{
        {1'b0, 1'b0, 8'h00, 16'h00A5, 8'd1},
        {1'b0, 1'b1, 8'h00, 16'h003C, 8'd0},
        {1'b1, 1'b0, 8'h80, 16'hBEEF, 8'd1},
        {1'b1, 1'b1, 8'h8C, 16'h0ABC, 8'd2},
        {1'b0, 1'b0, 8'h85, 16'h1234, 8'd0},
        {1'b0, 1'b1, 8'h8F, 16'h7FFE, 8'd0},
        {1'b1, 1'b0, 8'h89, 16'h01FF, 8'd3},
        {1'b1, 1'b1, 8'h08, 16'hFFC3, 8'd0}
    };

    // serial monitor, sampled on the falling clock edge
    logic        m_cpol = 1'b0, m_cpha = 1'b0;
    logic        prev_sclk = 1'b0, prev_cs = 1'b1;
    logic [15:0] m_word = '0;
    int          m_bits = 0, m_low = 0, m_xf = 0;
    logic [15:0] log_w [64];
    int          log_b [64];
    int          log_l [64];

    always @(negedge clk) begin
        if (!rst) begin
            if (spi_sclk !== prev_sclk && !prev_cs) begin
                if ((prev_sclk == m_cpol) ^ m_cpha) begin
                    m_word = {m_word[14:0], spi_mosi};
                    m_bits++;
                end
            end
            if (prev_cs && !spi_cs_n) begin
                m_word = '0; m_bits = 0; m_low = 0;
            end
            if (!spi_cs_n) m_low++;
            if (!prev_cs && spi_cs_n) begin
                log_w[m_xf[5:0]] = m_word;
                log_b[m_xf[5:0]] = m_bits;
                log_l[m_xf[5:0]] = m_low;
                m_xf++;
            end
        end
        prev_sclk = spi_sclk;
        prev_cs   = spi_cs_n;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        hst_sel = s; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] s, output logic [15:0] d);
        @(negedge clk);
        hst_sel = s; hst_rd = 1'b1;
        #1 d = hst_rdata;
        @(negedge clk);
        hst_rd = 1'b0;
    endtask

    task automatic wait_fin();
        for (int k = 0; k < 3000 && !q_finished; k++) @(negedge clk);
    endtask

    function automatic int blen(input logic [7:0] c);
        if (!c[7]) return 8;
        if (c[3:0] == 4'd0) return 16;
        if (c[3:0] < 4'd8) return 8;
        return int'(c[3:0]);
    endfunction

    function automatic logic [15:0] bmask(input int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    logic [15:0] rd;
    int          base;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 cs_n", 32'(spi_cs_n), 32'd1);
        check("R1 sclk", 32'(spi_sclk), 32'd0);
        check("R1 flag", 32'(q_finished), 32'd0);
        host_rd(3'd1, rd); check("R1 mode", 32'(rd), 32'd0);
        host_rd(3'd2, rd); check("R1 qptr", 32'(rd), 32'd0);
        host_rd(3'd4, rd); check("R1 addr", 32'(rd), 32'd0);

        // R7: default pointers give a single transfer of slot 0
        host_wr(3'd4, 16'h0000); host_wr(3'd5, 16'h005A);
        host_wr(3'd4, 16'h0020); host_wr(3'd5, 16'h0000);
        base = m_xf;
        host_wr(3'd1, 16'h0001);
        wait_fin();
        repeat (60) @(negedge clk);
        check("R7 count", 32'(m_xf - base), 32'd1);
        check("R7 word", 32'(log_w[base[5:0]]), 32'h5A);
        host_rd(3'd2, rd); check("R7 cpt", 32'(rd[15:12]), 32'd0);
        host_wr(3'd3, 16'h0001);

        // vector table: modes, lengths, dividers
        for (int i = 0; i < 8; i++) begin
            logic [33:0] v;
            int n;
            v = VEC[i];
            n = blen(v[31:24]);
            m_cpol = v[33]; m_cpha = v[32];
            host_wr(3'd4, 16'(i));        host_wr(3'd5, v[23:8]);
            host_wr(3'd4, 16'(32 + i));   host_wr(3'd5, {8'h00, v[31:24]});
            host_wr(3'd0, {8'h00, v[7:0]});
            host_wr(3'd2, 16'((i << 4) | i));
            host_wr(3'd1, {13'd0, v[33], v[32], 1'b0});
            base = m_xf;
            host_wr(3'd1, {13'd0, v[33], v[32], 1'b1});
            wait_fin();
            repeat (2) @(negedge clk);
            check("R4 one transfer", 32'(m_xf - base), 32'd1);
            check("R9 msb-first out", 32'(log_w[base[5:0]]), 32'(v[23:8] & bmask(n)));
            check("R10 length", 32'(log_b[base[5:0]]), 32'(n));
            check("R11 cs low time", 32'(log_l[base[5:0]]), 32'(2 * n * (int'(v[7:0]) + 1)));
            check("R9 idle level", 32'(spi_sclk), 32'(v[33]));
            host_wr(3'd4, 16'(16 + i));
            host_rd(3'd5, rd); check("R9 rx word", 32'(rd), 32'(~v[23:8] & bmask(n)));
            host_rd(3'd2, rd); check("R4 cpt", 32'(rd[15:12]), 32'(i));
            host_rd(3'd1, rd); check("R5 enable cleared", 32'(rd[0]), 32'd0);
            host_rd(3'd3, rd); check("R5 flag", 32'(rd[0]), 32'd1);
            host_wr(3'd3, 16'h0001);
        end

        // R2/R3: address stepping and segment directions
        host_wr(3'd4, 16'h000F);
        host_rd(3'd5, rd); check("R3 tx read zero", 32'(rd), 32'd0);
        host_rd(3'd5, rd); check("R2 step into rx", 32'(rd), 32'h5A);
        host_rd(3'd4, rd); check("R2 addr readback", 32'(rd), 32'h11);
        host_wr(3'd4, 16'h0012); host_wr(3'd5, 16'hFFFF);
        host_wr(3'd4, 16'h0012);
        host_rd(3'd5, rd); check("R3 rx write ignored", 32'(rd), 32'h4110);
        host_wr(3'd4, 16'h0021);
        host_rd(3'd5, rd); check("R3 cmd read zero", 32'(rd), 32'd0);
        host_wr(3'd4, 16'h0030);
        host_rd(3'd5, rd); check("R3 unmapped read zero", 32'(rd), 32'd0);

        // R4/R5: multi-slot queue from 1 to 3
        m_cpol = 1'b0; m_cpha = 1'b0;
        host_wr(3'd0, 16'h0000);
        host_wr(3'd1, 16'h0000);
        host_wr(3'd4, 16'h0000);
        for (int k = 0; k < 4; k++) host_wr(3'd5, 16'(16'h00C0 + k));
        host_wr(3'd4, 16'h0020);
        for (int k = 0; k < 4; k++) host_wr(3'd5, 16'h0000);
        host_wr(3'd2, 16'h0031);
        base = m_xf;
        host_wr(3'd1, 16'h0001);
        wait_fin();
        repeat (40) @(negedge clk);
        check("R4 queue count", 32'(m_xf - base), 32'd3);
        check("R4 first slot", 32'(log_w[base[5:0]]), 32'hC1);
        check("R4 last slot", 32'(log_w[6'(base + 2)]), 32'hC3);
        host_rd(3'd2, rd); check("R5 cpt at end", 32'(rd[15:12]), 32'd3);
        host_rd(3'd1, rd); check("R5 stopped", 32'(rd[0]), 32'd0);

        // R12: clear-by-writing-one
        host_wr(3'd3, 16'h0000);
        host_rd(3'd3, rd); check("R12 zero write keeps", 32'(rd[0]), 32'd1);
        host_wr(3'd3, 16'h0001);
        @(negedge clk);
        check("R12 one write clears", 32'(q_finished), 32'd0);

        // R6: wraparound from 14 past 15 to 0
        host_wr(3'd4, 16'h000E); host_wr(3'd5, 16'h00E1); host_wr(3'd5, 16'h00F2);
        host_wr(3'd4, 16'h002E); host_wr(3'd5, 16'h0000); host_wr(3'd5, 16'h0000);
        host_wr(3'd2, 16'h011E);
        base = m_xf;
        host_wr(3'd1, 16'h0001);
        wait_fin();
        check("R6 count at end", 32'(m_xf - base), 32'd4);
        host_rd(3'd2, rd); check("R6 cpt at end", 32'(rd[15:12]), 32'd1);
        host_wr(3'd1, 16'h0000);
        repeat (60) @(negedge clk);
        check("R6 continued once", 32'(m_xf - base), 32'd5);
        check("R6 slot 15", 32'(log_w[6'(base + 1)]), 32'hF2);
        check("R6 wrap to 0", 32'(log_w[6'(base + 2)]), 32'hC0);
        check("R6 last slot", 32'(log_w[6'(base + 4)]), 32'hC2);
        host_rd(3'd2, rd); check("R6 cpt after disable", 32'(rd[15:12]), 32'd2);
        host_wr(3'd3, 16'h0001);

        // R8: start pointer moved during a long transfer
        host_wr(3'd0, 16'h0003);
        host_wr(3'd4, 16'h0000); host_wr(3'd5, 16'hC3A5);
        for (int k = 1; k < 6; k++) host_wr(3'd5, 16'(16'h0010 + k));
        host_wr(3'd4, 16'h0020); host_wr(3'd5, 16'h0080);
        for (int k = 1; k < 6; k++) host_wr(3'd5, 16'h0000);
        host_wr(3'd2, 16'h0050);
        base = m_xf;
        host_wr(3'd1, 16'h0001);
        for (int k = 0; k < 100 && spi_cs_n; k++) @(negedge clk);
        host_wr(3'd2, 16'h0054);
        wait_fin();
        repeat (4) @(negedge clk);
        check("R8 count", 32'(m_xf - base), 32'd3);
        check("R8 first word whole", 32'(log_w[base[5:0]]), 32'hC3A5);
        check("R8 first length", 32'(log_b[base[5:0]]), 32'd16);
        check("R8 jumped slot", 32'(log_w[6'(base + 1)]), 32'h14);
        check("R8 end slot", 32'(log_w[6'(base + 2)]), 32'h15);
        host_rd(3'd2, rd); check("R8 cpt", 32'(rd[15:12]), 32'd5);

        all_done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!all_done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule